// File: doc/BRIEF.md
# Two-Frame Gradient and Initial Flow Estimator

This block is the front end of an iterative gradient-based optical flow pipeline. It takes one pixel of the previous frame and the co-located pixel of the current frame per transfer, in raster order. Line buffers and one-pixel delays give it, for every position, the 2×2 block of each frame that ends at that pixel. Together the two blocks form a small space-time cube. From the cube it derives the horizontal, vertical and temporal brightness gradients. A gradient whose magnitude is below a runtime dead-zone level is forced to zero.

From the gradients it forms the normaliser (the squared smoothness weight plus both squared spatial gradients). It also forms a first flow estimate in which the neighbourhood mean flow is taken as zero. The normaliser, both flow components and the three gradients leave the block together for one pixel. A chain of refinement stages downstream can then reuse the gradients and the normaliser unchanged.

Both streams use valid/ready. A transfer takes place on a rising clock edge where valid and ready are both high. The whole pipeline advances as one: it moves whenever the output register is empty or is being taken. `in_ready` is therefore combinationally `!out_valid || out_ready`. While the consumer holds `out_ready` low with a result pending, nothing moves and no input is accepted. Frames must arrive complete, with `IMG_W`×`IMG_H` pixels each, back to back.

Top module: `hs_flow_init`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and every output field stay unchanged on the next cycle.
- R2: A result is produced only for pixels whose column and row within the frame are both at least 1. Each frame therefore yields (IMG_W−1)·(IMG_H−1) results, in raster order, with none lost or duplicated.
- R3: The cube has four corners per frame: top-left a, top-right b, bottom-left c and bottom-right d, where d is the current pixel. `out_ix` is the floor, toward minus infinity, of one quarter of (b−a)+(d−c), summed over both frames. It is signed two's complement, PIX_W+1 bits.
- R4: `out_iy` is the floor of one quarter of (c−a)+(d−b), summed over both frames, in the same signed format.
- R5: `out_it` is the floor of one quarter of the sum, over the four corners, of current-frame value minus previous-frame value.
- R6: Each gradient whose magnitude is below `dz_thresh` (unsigned) is output as zero. A level of 0 disables the dead zone.
- R7: `out_psi` (unsigned, 2·PIX_W+2 bits) equals `smooth_sq + ix² + iy²`, computed from the gradients after the dead zone.
- R8: `out_u0` equals −ix·it·2^FRAC / psi and `out_v0` equals −iy·it·2^FRAC / psi. The quotient is truncated toward zero and the result is signed two's complement with FRAC fraction bits.
- R9: When psi is zero, both `out_u0` and `out_v0` are zero.
- R10: All output fields belong to the same pixel. Without back-pressure, a result appears 2 + 2·PIX_W + FRAC cycles after its pixel is accepted.

The `dz_thresh` and `smooth_sq` inputs must stay constant while any pixel of a frame is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel pair offered |
| in_ready | output | 1 | Block accepts the pair this cycle |
| in_prev | input | PIX_W | Previous-frame pixel |
| in_cur | input | PIX_W | Current-frame pixel at the same position |
| dz_thresh | input | PIX_W | Dead-zone level for the gradients |
| smooth_sq | input | 2·PIX_W | Squared smoothness weight added to psi |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ix | output | PIX_W+1 | Horizontal gradient, signed |
| out_iy | output | PIX_W+1 | Vertical gradient, signed |
| out_it | output | PIX_W+1 | Temporal gradient, signed |
| out_psi | output | 2·PIX_W+2 | Normaliser, unsigned |
| out_u0 | output | 2·PIX_W+FRAC+1 | Initial horizontal flow, signed fixed point |
| out_v0 | output | 2·PIX_W+FRAC+1 | Initial vertical flow, signed fixed point |

## Verification
The case that needs the most care is a stalled result at the output in the same cycle that a new pixel pair is offered at the input. That new pair would update the line buffers and the column and row position. The bench drives `in_valid` and `out_ready` from independent random draws, so this collision happens often. In each such cycle it checks that the held result does not change and that no pixel is consumed. It also checks that every result, once it is taken, matches a model built from the pixels that were actually accepted. A second collision is checked as well: the dead zone clearing every gradient while `smooth_sq` is zero, which sends a zero normaliser into the divider. A frame of that kind is driven, and zero flow is required.

// File: rtl/hsfi_pkg.sv
package hsfi_pkg;
  localparam int PIX_W_DEF = 8;
  localparam int FRAC_DEF  = 8;
  localparam int IMG_W_DEF = 16;
  localparam int IMG_H_DEF = 8;

  // gradient width: quarter of four pixel differences fits one extra bit
  function automatic int der_w(input int p);
    return p + 1;
  endfunction

  // normaliser width: weight plus two squared gradients
  function automatic int psi_w(input int p);
    return 2 * (p + 1);
  endfunction

  // dividend width: product magnitude shifted by the fraction bits
  function automatic int num_w(input int p, input int f);
    return 2 * p + f;
  endfunction

  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/hsfi_window.sv
module hsfi_window
  import hsfi_pkg::*;
#(
  parameter int PIX_W = PIX_W_DEF,
  parameter int IMG_W = IMG_W_DEF,
  parameter int IMG_H = IMG_H_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    in_valid,
  input  logic [PIX_W-1:0]        in_prev,
  input  logic [PIX_W-1:0]        in_cur,
  input  logic [PIX_W-1:0]        dz_thresh,
  output logic                    a_v,
  output logic signed [PIX_W:0]   a_ix,
  output logic signed [PIX_W:0]   a_iy,
  output logic signed [PIX_W:0]   a_it
);
  localparam int DW = der_w(PIX_W);
  localparam int CW = cnt_w(IMG_W);
  localparam int RW = cnt_w(IMG_H);
  localparam int SW = PIX_W + 4;

  logic [CW-1:0]    col;
  logic [RW-1:0]    row;
  logic [PIX_W-1:0] lb_p [IMG_W];
  logic [PIX_W-1:0] lb_c [IMG_W];
  logic [PIX_W-1:0] left_p, left_c, ul_p, ul_c;
  logic             acc;

  assign acc = adv && in_valid;

  function automatic logic signed [SW-1:0] ext(input logic [PIX_W-1:0] p);
    return $signed({4'b0000, p});
  endfunction

  function automatic logic [DW-1:0] mag(input logic signed [DW-1:0] d);
    return d[DW-1] ? DW'(-d) : DW'(d);
  endfunction

  function automatic logic signed [DW-1:0] deadzone(input logic signed [DW-1:0] d,
                                                    input logic [PIX_W-1:0] t);
    return (mag(d) < {1'b0, t}) ? '0 : d;
  endfunction

  logic signed [SW-1:0] pa, pb, pc, pd, ca, cb, cc, cd;
  logic signed [SW-1:0] sx, sy, st, qx, qy, qt;

  always_comb begin
    pa = ext(ul_p);   pb = ext(lb_p[col]); pc = ext(left_p); pd = ext(in_prev);
    ca = ext(ul_c);   cb = ext(lb_c[col]); cc = ext(left_c); cd = ext(in_cur);
    sx = (pb - pa) + (pd - pc) + (cb - ca) + (cd - cc);
    sy = (pc - pa) + (pd - pb) + (cc - ca) + (cd - cb);
    st = (ca - pa) + (cb - pb) + (cc - pc) + (cd - pd);
    qx = sx >>> 2;
    qy = sy >>> 2;
    qt = st >>> 2;
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      lb_p[col] <= in_prev;
      lb_c[col] <= in_cur;
      left_p    <= in_prev;
      left_c    <= in_cur;
      ul_p      <= lb_p[col];
      ul_c      <= lb_c[col];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col  <= '0;
      row  <= '0;
      a_v  <= 1'b0;
      a_ix <= '0;
      a_iy <= '0;
      a_it <= '0;
    end else if (adv) begin
      a_v <= acc && (col != '0) && (row != '0);
      if (acc) begin
        a_ix <= deadzone(qx[DW-1:0], dz_thresh);
        a_iy <= deadzone(qy[DW-1:0], dz_thresh);
        a_it <= deadzone(qt[DW-1:0], dz_thresh);
        if (col == CW'(IMG_W - 1)) begin
          col <= '0;
          row <= (row == RW'(IMG_H - 1)) ? '0 : row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

  AST_BORDER_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (col == '0 || row == '0)) |=> !a_v); // R2

  AST_DEAD_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
    a_v |-> ((a_ix == '0 || mag(a_ix) >= {1'b0, dz_thresh}) &&
             (a_iy == '0 || mag(a_iy) >= {1'b0, dz_thresh}) &&
             (a_it == '0 || mag(a_it) >= {1'b0, dz_thresh}))); // R6
endmodule

// File: rtl/hsfi_norm.sv
module hsfi_norm
  import hsfi_pkg::*;
#(
  parameter int PIX_W = PIX_W_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     a_v,
  input  logic signed [PIX_W:0]    a_ix,
  input  logic signed [PIX_W:0]    a_iy,
  input  logic signed [PIX_W:0]    a_it,
  input  logic [2*PIX_W-1:0]       smooth_sq,
  output logic                     b_v,
  output logic signed [PIX_W:0]    b_ix,
  output logic signed [PIX_W:0]    b_iy,
  output logic signed [PIX_W:0]    b_it,
  output logic [2*PIX_W+1:0]       b_psi,
  output logic [2*PIX_W-1:0]       b_mu,
  output logic [2*PIX_W-1:0]       b_mv,
  output logic                     b_nu,
  output logic                     b_nv
);
  localparam int DW = der_w(PIX_W);
  localparam int PW = psi_w(PIX_W);
  localparam int MW = 2 * PIX_W;

  logic signed [2*DW-1:0] sq_x, sq_y, pr_u, pr_v, ab_u, ab_v;
  logic [PW-1:0]          psi_c;

  always_comb begin
    sq_x  = a_ix * a_ix;
    sq_y  = a_iy * a_iy;
    pr_u  = a_ix * a_it;
    pr_v  = a_iy * a_it;
    ab_u  = pr_u[2*DW-1] ? -pr_u : pr_u;
    ab_v  = pr_v[2*DW-1] ? -pr_v : pr_v;
    psi_c = PW'(smooth_sq) + PW'(sq_x) + PW'(sq_y);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_v <= 1'b0; b_ix <= '0; b_iy <= '0; b_it <= '0;
      b_psi <= '0; b_mu <= '0; b_mv <= '0; b_nu <= 1'b0; b_nv <= 1'b0;
    end else if (adv) begin
      b_v   <= a_v;
      b_ix  <= a_ix;
      b_iy  <= a_iy;
      b_it  <= a_it;
      b_psi <= psi_c;
      b_mu  <= ab_u[MW-1:0];
      b_mv  <= ab_v[MW-1:0];
      // flow is minus the product over psi: negative when the product is positive
      b_nu  <= (pr_u > 0);
      b_nv  <= (pr_v > 0);
    end
  end
endmodule

// File: rtl/hsfi_divpipe.sv
module hsfi_divpipe
  import hsfi_pkg::*;
#(
  parameter int PIX_W = PIX_W_DEF,
  parameter int FRAC  = FRAC_DEF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          adv,
  input  logic                          b_v,
  input  logic signed [PIX_W:0]         b_ix,
  input  logic signed [PIX_W:0]         b_iy,
  input  logic signed [PIX_W:0]         b_it,
  input  logic [2*PIX_W+1:0]            b_psi,
  input  logic [2*PIX_W-1:0]            b_mu,
  input  logic [2*PIX_W-1:0]            b_mv,
  input  logic                          b_nu,
  input  logic                          b_nv,
  output logic                          z_v,
  output logic signed [PIX_W:0]         z_ix,
  output logic signed [PIX_W:0]         z_iy,
  output logic signed [PIX_W:0]         z_it,
  output logic [2*PIX_W+1:0]            z_psi,
  output logic signed [2*PIX_W+FRAC:0]  z_u0,
  output logic signed [2*PIX_W+FRAC:0]  z_v0
);
  localparam int DW  = der_w(PIX_W);
  localparam int PW  = psi_w(PIX_W);
  localparam int NW  = num_w(PIX_W, FRAC);
  localparam int RW1 = PW + 1;
  localparam int FW  = NW + 1;

  typedef struct packed {
    logic          v;
    logic [PW-1:0] psi;
    logic [DW-1:0] ix;
    logic [DW-1:0] iy;
    logic [DW-1:0] it;
    logic          nu;
    logic          nv;
    logic [RW1-1:0] ru;
    logic [RW1-1:0] rv;
    logic [NW-1:0] du;
    logic [NW-1:0] dv;
    logic [NW-1:0] qu;
    logic [NW-1:0] qv;
  } st_t;

  st_t s0;
  st_t s [1:NW];

  always_comb begin
    s0     = '0;
    s0.v   = b_v;
    s0.psi = b_psi;
    s0.ix  = b_ix;
    s0.iy  = b_iy;
    s0.it  = b_it;
    s0.nu  = b_nu;
    s0.nv  = b_nv;
    s0.du  = {b_mu, {FRAC{1'b0}}};
    s0.dv  = {b_mv, {FRAC{1'b0}}};
  end

  for (genvar k = 0; k < NW; k++) begin : g_stage
    st_t            cur;
    logic [RW1:0]   tu, tv;
    logic           gu, gv;

    if (k == 0) begin : g_first
      assign cur = s0;
    end else begin : g_next
      assign cur = s[k];
    end

    always_comb begin
      tu = {cur.ru, cur.du[NW-1]};
      tv = {cur.rv, cur.dv[NW-1]};
      gu = (tu >= {2'b00, cur.psi});
      gv = (tv >= {2'b00, cur.psi});
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s[k+1] <= '0;
      end else if (adv) begin
        s[k+1]    <= cur;
        s[k+1].ru <= gu ? RW1'(tu - {2'b00, cur.psi}) : tu[RW1-1:0];
        s[k+1].rv <= gv ? RW1'(tv - {2'b00, cur.psi}) : tv[RW1-1:0];
        s[k+1].du <= {cur.du[NW-2:0], 1'b0};
        s[k+1].dv <= {cur.dv[NW-2:0], 1'b0};
        s[k+1].qu <= {cur.qu[NW-2:0], gu};
        s[k+1].qv <= {cur.qv[NW-2:0], gv};
      end
    end
  end

  st_t last;
  logic [FW-1:0] qu_w, qv_w;

  always_comb begin
    last  = s[NW];
    qu_w  = {1'b0, last.qu};
    qv_w  = {1'b0, last.qv};
    z_v   = last.v;
    z_ix  = $signed(last.ix);
    z_iy  = $signed(last.iy);
    z_it  = $signed(last.it);
    z_psi = last.psi;
    if (last.psi == '0) begin
      z_u0 = '0;
      z_v0 = '0;
    end else begin
      z_u0 = last.nu ? $signed(-qu_w) : $signed(qu_w);
      z_v0 = last.nv ? $signed(-qv_w) : $signed(qv_w);
    end
  end

  // reference bounds for the quotient, taken from the carried gradients
  longint chk_pu, chk_pv, chk_mu, chk_mv, chk_qu, chk_qv, chk_ps;
  always_comb begin
    chk_pu = longint'($signed(last.ix)) * longint'($signed(last.it));
    chk_pv = longint'($signed(last.iy)) * longint'($signed(last.it));
    chk_mu = (chk_pu < 0 ? -chk_pu : chk_pu) * (longint'(1) << FRAC);
    chk_mv = (chk_pv < 0 ? -chk_pv : chk_pv) * (longint'(1) << FRAC);
    chk_qu = longint'(last.qu);
    chk_qv = longint'(last.qv);
    chk_ps = longint'(last.psi);
  end

  AST_ZERO_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    (z_v && z_psi == '0) |-> (z_u0 == '0 && z_v0 == '0)); // R9

  AST_QUOT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (z_v && z_psi != '0) |-> (chk_qu * chk_ps <= chk_mu && chk_mu < (chk_qu + 1) * chk_ps &&
                              chk_qv * chk_ps <= chk_mv && chk_mv < (chk_qv + 1) * chk_ps)); // R8
endmodule

// File: rtl/hs_flow_init.sv
module hs_flow_init
  import hsfi_pkg::*;
#(
  parameter int PIX_W = PIX_W_DEF,
  parameter int FRAC  = FRAC_DEF,
  parameter int IMG_W = IMG_W_DEF,
  parameter int IMG_H = IMG_H_DEF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [PIX_W-1:0]              in_prev,
  input  logic [PIX_W-1:0]              in_cur,
  input  logic [PIX_W-1:0]              dz_thresh,
  input  logic [2*PIX_W-1:0]            smooth_sq,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic signed [PIX_W:0]         out_ix,
  output logic signed [PIX_W:0]         out_iy,
  output logic signed [PIX_W:0]         out_it,
  output logic [2*PIX_W+1:0]            out_psi,
  output logic signed [2*PIX_W+FRAC:0]  out_u0,
  output logic signed [2*PIX_W+FRAC:0]  out_v0
);
  logic                  adv;
  logic                  a_v, b_v;
  logic signed [PIX_W:0] a_ix, a_iy, a_it, b_ix, b_iy, b_it;
  logic [2*PIX_W+1:0]    b_psi;
  logic [2*PIX_W-1:0]    b_mu, b_mv;
  logic                  b_nu, b_nv;

  // single advance for every stage: move when the output slot frees up
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  hsfi_window #(.PIX_W(PIX_W), .IMG_W(IMG_W), .IMG_H(IMG_H)) u_window (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(in_valid),
    .in_prev(in_prev), .in_cur(in_cur), .dz_thresh(dz_thresh),
    .a_v(a_v), .a_ix(a_ix), .a_iy(a_iy), .a_it(a_it)
  );

  hsfi_norm #(.PIX_W(PIX_W)) u_norm (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .a_v(a_v), .a_ix(a_ix), .a_iy(a_iy), .a_it(a_it), .smooth_sq(smooth_sq),
    .b_v(b_v), .b_ix(b_ix), .b_iy(b_iy), .b_it(b_it), .b_psi(b_psi),
    .b_mu(b_mu), .b_mv(b_mv), .b_nu(b_nu), .b_nv(b_nv)
  );

  hsfi_divpipe #(.PIX_W(PIX_W), .FRAC(FRAC)) u_div (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .b_v(b_v), .b_ix(b_ix), .b_iy(b_iy), .b_it(b_it), .b_psi(b_psi),
    .b_mu(b_mu), .b_mv(b_mv), .b_nu(b_nu), .b_nv(b_nv),
    .z_v(out_valid), .z_ix(out_ix), .z_iy(out_iy), .z_it(out_it),
    .z_psi(out_psi), .z_u0(out_u0), .z_v0(out_v0)
  );

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ix) && $stable(out_iy) &&
      $stable(out_it) && $stable(out_psi) && $stable(out_u0) && $stable(out_v0))); // R1

  AST_PSI_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_psi >= {{PIX_W{1'b0}}, smooth_sq} + 0)); // R7
endmodule

// File: tb/test_hs_flow_init.sv
module test_hs_flow_init;
  localparam int PIX_W = 8;
  localparam int FRAC  = 8;
  localparam int IMG_W = 16;
  localparam int IMG_H = 8;
  localparam int NW    = 2 * PIX_W + FRAC;
  localparam int LAT   = NW + 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [PIX_W-1:0]     in_prev, in_cur, dz_thresh;
  logic [2*PIX_W-1:0]   smooth_sq;
  logic signed [PIX_W:0] out_ix, out_iy, out_it;
  logic [2*PIX_W+1:0]   out_psi;
  logic signed [NW:0]   out_u0, out_v0;

  hs_flow_init #(.PIX_W(PIX_W), .FRAC(FRAC), .IMG_W(IMG_W), .IMG_H(IMG_H)) i_hs_flow_init (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_prev(in_prev), .in_cur(in_cur), .dz_thresh(dz_thresh), .smooth_sq(smooth_sq),
    .out_valid(out_valid), .out_ready(out_ready), .out_ix(out_ix), .out_iy(out_iy),
    .out_it(out_it), .out_psi(out_psi), .out_u0(out_u0), .out_v0(out_v0)
  );

  typedef struct {
    int     ix, iy, it, rix, riy, rit;
    longint psi, u, v;
    int     stamp;
    bit     timed;
  } exp_t;

  exp_t   q[$];
  int     f1 [IMG_H][IMG_W];
  int     f2 [IMG_H][IMG_W];
  int     n_chk = 0, n_fail = 0, cyc = 0, n_out = 0, n_frames = 0;
  bit     timed = 1'b0, done = 1'b0, hold = 1'b0;
  longint snap [6];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int floor4(input int s);
    return (s >= 0) ? s / 4 : -((-s + 3) / 4);
  endfunction

  function automatic int dz(input int d, input int t);
    return ((d < 0 ? -d : d) < t) ? 0 : d;
  endfunction

  task automatic accept(input int idx);
    int r, c, a1, b1, c1, d1, a2, b2, c2, d2;
    exp_t e;
    r = idx / IMG_W;
    c = idx % IMG_W;
    if (r == 0 || c == 0) return;
    a1 = f1[r-1][c-1]; b1 = f1[r-1][c]; c1 = f1[r][c-1]; d1 = f1[r][c];
    a2 = f2[r-1][c-1]; b2 = f2[r-1][c]; c2 = f2[r][c-1]; d2 = f2[r][c];
    e.rix = floor4((b1 - a1) + (d1 - c1) + (b2 - a2) + (d2 - c2));
    e.riy = floor4((c1 - a1) + (d1 - b1) + (c2 - a2) + (d2 - b2));
    e.rit = floor4((a2 - a1) + (b2 - b1) + (c2 - c1) + (d2 - d1));
    e.ix  = dz(e.rix, int'(dz_thresh));
    e.iy  = dz(e.riy, int'(dz_thresh));
    e.it  = dz(e.rit, int'(dz_thresh));
    e.psi = longint'(smooth_sq) + longint'(e.ix * e.ix) + longint'(e.iy * e.iy);
    if (e.psi == 0) begin
      e.u = 0;
      e.v = 0;
    end else begin
      e.u = (-longint'(e.ix * e.it) * (longint'(1) << FRAC)) / e.psi;
      e.v = (-longint'(e.iy * e.it) * (longint'(1) << FRAC)) / e.psi;
    end
    e.stamp = cyc;
    e.timed = timed;
    q.push_back(e);
  endtask

  task automatic observe();
    exp_t e;
    if (hold) begin
      chk(out_valid && snap[0] == longint'(out_ix) && snap[1] == longint'(out_iy) &&
          snap[2] == longint'(out_it) && snap[3] == longint'(out_psi) &&
          snap[4] == longint'(out_u0) && snap[5] == longint'(out_v0),
          "R1", "held result changed", longint'(out_u0), snap[4]);
      chk(in_ready == out_ready, "R1", "in_ready under stall", longint'(in_ready), longint'(out_ready));
    end
    if (out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R2", "unexpected result", 1, 0);
      end else begin
        e = q.pop_front();
        n_out++;
        chk(int'(out_ix) == e.ix, (e.ix != e.rix) ? "R6" : "R3", "ix", longint'(out_ix), e.ix);
        chk(int'(out_iy) == e.iy, (e.iy != e.riy) ? "R6" : "R4", "iy", longint'(out_iy), e.iy);
        chk(int'(out_it) == e.it, (e.it != e.rit) ? "R6" : "R5", "it", longint'(out_it), e.it);
        chk(longint'(out_psi) == e.psi, "R7", "psi", longint'(out_psi), e.psi);
        chk(longint'(out_u0) == e.u, (e.psi == 0) ? "R9" : "R8", "u0", longint'(out_u0), e.u);
        chk(longint'(out_v0) == e.v, (e.psi == 0) ? "R9" : "R8", "v0", longint'(out_v0), e.v);
        if (e.timed)
          chk(cyc - e.stamp == LAT, "R10", "latency", cyc - e.stamp, LAT);
      end
    end
    hold = out_valid && !out_ready;
    snap[0] = longint'(out_ix); snap[1] = longint'(out_iy); snap[2] = longint'(out_it);
    snap[3] = longint'(out_psi); snap[4] = longint'(out_u0); snap[5] = longint'(out_v0);
  endtask

  task automatic one_cycle(input bit offer, input int idx, input int pr, output bit took);
    @(negedge clk);
    in_valid  = offer;
    in_prev   = PIX_W'(f1[idx / IMG_W][idx % IMG_W]);
    in_cur    = PIX_W'(f2[idx / IMG_W][idx % IMG_W]);
    out_ready = ($urandom % 100) < pr;
    #1;
    observe();
    took = in_valid && in_ready;
    chk(in_ready == (!out_valid || out_ready), "R1", "ready rule", longint'(in_ready),
        longint'(!out_valid || out_ready));
    if (took) accept(idx);
    cyc++;
  endtask

  task automatic run_frame(input int pv, input int pr, input bit tm);
    int  idx;
    bit  took;
    timed = tm;
    idx   = 0;
    while (idx < IMG_W * IMG_H) begin
      one_cycle(($urandom % 100) < pv, idx, pr, took);
      if (took) idx++;
    end
    while (q.size() > 0) one_cycle(1'b0, 0, pr, took);
    for (int k = 0; k < 4; k++) one_cycle(1'b0, 0, pr, took);
    n_frames++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_prev = '0; in_cur = '0; dz_thresh = '0; smooth_sq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1", "reset out_valid", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "reset in_ready", longint'(in_ready), 1);

    // flat frames, no weight: zero normaliser everywhere (R9), timed (R10)
    for (int r = 0; r < IMG_H; r++) for (int c = 0; c < IMG_W; c++) begin
      f1[r][c] = 77; f2[r][c] = 77;
    end
    run_frame(100, 100, 1'b1);

    // ramps with a uniform temporal step (R3 R4 R5 R8), timed
    smooth_sq = 16'd100;
    for (int r = 0; r < IMG_H; r++) for (int c = 0; c < IMG_W; c++) begin
      f1[r][c] = c * 9 + r * 2; f2[r][c] = c * 9 + r * 2 + 20;
    end
    run_frame(100, 100, 1'b1);

    // same ramps with a dead zone removing the vertical gradient (R6)
    dz_thresh = 8'd5;
    run_frame(70, 60, 1'b0);

    // dead zone clearing every gradient with no weight: zero normaliser (R6 R9)
    smooth_sq = 16'd0;
    dz_thresh = 8'd200;
    run_frame(80, 50, 1'b0);

    // step edges at full swing
    dz_thresh = 8'd0;
    smooth_sq = 16'd0;
    for (int r = 0; r < IMG_H; r++) for (int c = 0; c < IMG_W; c++) begin
      f1[r][c] = (c < IMG_W / 2) ? 0 : 255; f2[r][c] = (r < IMG_H / 2) ? 255 : 0;
    end
    run_frame(90, 40, 1'b0);

    // low-noise pairs around the dead zone
    dz_thresh = 8'd3;
    smooth_sq = 16'd50;
    for (int r = 0; r < IMG_H; r++) for (int c = 0; c < IMG_W; c++) begin
      f1[r][c] = 100 + int'($urandom % 50); f2[r][c] = f1[r][c] + int'($urandom % 7) - 3;
    end
    run_frame(60, 70, 1'b0);

    // fully random frames and settings
    for (int fr = 0; fr < 4; fr++) begin
      dz_thresh = PIX_W'($urandom % 16);
      smooth_sq = (fr == 0) ? 16'd1 : 16'($urandom);
      for (int r = 0; r < IMG_H; r++) for (int c = 0; c < IMG_W; c++) begin
        f1[r][c] = int'($urandom % 256); f2[r][c] = int'($urandom % 256);
      end
      run_frame(30 + fr * 20, 90 - fr * 20, 1'b0);
    end

    chk(n_out == n_frames * (IMG_W - 1) * (IMG_H - 1), "R2", "result count",
        n_out, n_frames * (IMG_W - 1) * (IMG_H - 1));
    chk(q.size() == 0, "R2", "results outstanding", q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule